// File: doc/BRIEF.md
# Vectorised Condition-Field Loop Sequencer

This block walks a vector of 4-bit condition fields held in a local register file, one element per clock. For each element it combines one bit, or the whole field, from two operand fields with a 2-input logical function given as a 4-bit truth table, which covers AND, OR, NOR, XOR and the rest. It writes the result into a destination field. The three operand fields are formed as a base index plus the element index, wrapping modulo the register file depth. The walk can run forward or in reverse. When the destination range overlaps a source range, a result written for one element feeds the elements processed after it.

Source and destination predicate masks decide, per element, whether the element is skipped, run with substituted source values, or has a forced value written to it. An optional data-dependent early exit tests the bit just written, against a polarity flag, after every element that writes. The first element that fails stops the walk and shrinks the vector length. The failing element is either counted in the new length or left out of it. The fields are loaded through a simple write port while the block is idle. A run begins with a start pulse, and a one-cycle done pulse ends it together with the final vector length.

Top module: `cr_vec_seq`

## Requirements
- R1: While idle, `ld_en` writes `ld_val` into field `ld_idx`, and the new value shows on `rf_flat` at the next clock. Field f occupies `rf_flat[4f+3:4f]`, and bit k of a field is `rf_flat[4f+k]`. Reset clears every field, `vl_out` and `done`.
- R2: With `rev` clear, elements are processed in the order 0, 1, …, VL-1, one per clock. Element i uses fields `ba_base+i`, `bb_base+i` and `bt_base+i`, each taken modulo NF. A write made for one element is visible to every element processed later.
- R3: With `rev` set, elements are processed from VL-1 down to 0. An AND whose B range sits one field above its destination range therefore cascades: once one element yields 0, every element processed after it also yields 0.
- R4: With `fld_mode` clear, the result is `op_tt[{a,b}]`, where a is bit `ba_sel` of the A field and b is bit `bb_sel` of the B field. The result replaces bit `bt_sel` of the destination field, and the other three bits are kept.
- R5: With `fld_mode` set, each bit k of the destination field becomes `op_tt[{A[k],B[k]}]`.
- R6: With `pred_en` set and `src_mask[i]` equal to 0, element i is skipped (no write) when `sz` is clear. When `sz` is set, both source fields are replaced with all zeros, or with all ones if `snz` is also set.
- R7: With `pred_en` set and `dst_mask[i]` equal to 0, element i is skipped when the destination zeroing flag is clear. When it is set, the destination bit (bit mode) or the whole field (field mode) is written with the value of `snz`, whatever the source mask says. With `pred_en` clear, both masks are ignored.
- R8: With `par_red` set, `dz` is ignored and `sz` acts as both the source and the destination zeroing flag.
- R9: With `ff_en` set, each element that writes is tested. The tested bit is the bit just written in bit mode, or bit `ff_sel` of the written field in field mode. The test passes when that bit differs from `ff_inv`. Skipped elements are not tested. The failing element's write is kept.
- R10: The first failure ends the run. `vl_out` becomes the number of elements processed before the failing one, plus 1 when `ff_vli` is set. Without a failure, `vl_out` becomes the effective VL. `vl_out` never exceeds the effective VL and changes only together with `done`.
- R11: The effective VL is `vl_in` clamped to MAXVL. `done` is high for exactly one cycle, at the edge that commits the last processed element. With an effective VL of 0, that is the edge that samples `start`, and `vl_out` becomes 0.
- R12: `start` and `ld_en` are ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load one field (idle only) |
| ld_idx | input | $clog2(NF) | Field index to load |
| ld_val | input | 4 | Value to load |
| start | input | 1 | Begin a run (idle only) |
| vl_in | input | $clog2(MAXVL+1) | Requested vector length |
| ba_base | input | $clog2(NF) | First A operand field |
| bb_base | input | $clog2(NF) | First B operand field |
| bt_base | input | $clog2(NF) | First destination field |
| ba_sel | input | 2 | A bit select (bit mode) |
| bb_sel | input | 2 | B bit select (bit mode) |
| bt_sel | input | 2 | Destination bit select (bit mode) |
| op_tt | input | 4 | Truth table indexed by {a,b} |
| fld_mode | input | 1 | 1 = whole-field operation |
| rev | input | 1 | 1 = reverse element order |
| pred_en | input | 1 | Enable predicate masks |
| src_mask | input | MAXVL | Source predicate, one bit per element |
| dst_mask | input | MAXVL | Destination predicate, one bit per element |
| sz | input | 1 | Source zeroing flag |
| dz | input | 1 | Destination zeroing flag |
| snz | input | 1 | Substitute ones instead of zeros |
| par_red | input | 1 | Use `sz` for both zeroing flags |
| ff_en | input | 1 | Enable the early-exit test |
| ff_inv | input | 1 | Invert the test polarity |
| ff_vli | input | 1 | Count the failing element in VL |
| ff_sel | input | 2 | Tested bit in field mode |
| rf_flat | output | 4*NF | All fields, packed |
| vl_out | output | $clog2(MAXVL+1) | Final vector length |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Random runs mix bit and field mode, both orders, every truth table, predicate masks with each zeroing variant, and early exit with both polarities and both counting rules. Each run is compared with a bench model on the full field file, the final length and the cycle on which done appears. Directed runs pit a reverse-order overlapping AND against the same run in forward order, so that a cascade and a single-element clear can be told apart. Other directed runs make the very first element fail with and without inclusive counting (length 0 against 1), request lengths of 0 and of more than MAXVL, and pulse start and load during a run to show that neither leaves a trace.

// File: rtl/cr_seq_pkg.sv
package cr_seq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_t;

  // Per-run settings latched on start
  typedef struct packed {
    logic [3:0] op_tt;
    logic       fld_mode;
    logic       rev;
    logic [1:0] ba_sel;
    logic [1:0] bb_sel;
    logic [1:0] bt_sel;
    logic       pred_en;
    logic       sz;
    logic       dz;
    logic       snz;
    logic       ff_en;
    logic       ff_inv;
    logic       ff_vli;
    logic [1:0] ff_sel;
  } seq_cfg_t;

  function automatic logic tt_eval(logic [3:0] tt, logic a, logic b);
    return tt[{a, b}];
  endfunction

endpackage

// File: rtl/cr_elem_unit.sv
module cr_elem_unit
  import cr_seq_pkg::*;
(
  input  seq_cfg_t   cfg,
  input  logic       src_p,
  input  logic       dst_p,
  input  logic [3:0] a_fld,
  input  logic [3:0] b_fld,
  input  logic [3:0] d_fld,
  output logic       wr_en,
  output logic [3:0] wr_val,
  output logic       fail
);

  logic       src_off;
  logic       dst_off;
  logic       dst_force;
  logic [3:0] a_v;
  logic [3:0] b_v;
  logic [3:0] fld_res;
  logic       bit_res;
  logic       tbit;

  always_comb begin
    src_off   = cfg.pred_en & ~src_p;
    dst_off   = cfg.pred_en & ~dst_p;
    dst_force = dst_off & cfg.dz;

    a_v = (src_off & cfg.sz) ? {4{cfg.snz}} : a_fld;
    b_v = (src_off & cfg.sz) ? {4{cfg.snz}} : b_fld;

    for (int k = 0; k < 4; k++) begin
      fld_res[k] = tt_eval(cfg.op_tt, a_v[k], b_v[k]);
    end
    bit_res = tt_eval(cfg.op_tt, a_v[cfg.ba_sel], b_v[cfg.bb_sel]);

    if (cfg.fld_mode) begin
      wr_val = dst_force ? {4{cfg.snz}} : fld_res;
    end else begin
      wr_val = d_fld;
      wr_val[cfg.bt_sel] = dst_force ? cfg.snz : bit_res;
    end

    wr_en = dst_force | ~((src_off & ~cfg.sz) | dst_off);
    tbit  = cfg.fld_mode ? wr_val[cfg.ff_sel] : wr_val[cfg.bt_sel];
    fail  = wr_en & cfg.ff_en & ~(tbit ^ cfg.ff_inv);
  end

endmodule

// File: rtl/cr_field_rf.sv
module cr_field_rf #(
  parameter int NF = 16,
  localparam int FW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [FW-1:0] ld_idx,
  input  logic [3:0]    ld_val,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_idx,
  input  logic [3:0]    wr_val,
  input  logic [FW-1:0] ra_idx,
  input  logic [FW-1:0] rb_idx,
  input  logic [FW-1:0] rd_idx,
  output logic [3:0]    ra_val,
  output logic [3:0]    rb_val,
  output logic [3:0]    rd_val,
  output logic [4*NF-1:0] flat
);

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic       hit_wr;
    logic       hit_ld;
    logic       fld_en;
    logic [3:0] fld_d;
    logic [3:0] fld_q;

    assign hit_wr = wr_en && (wr_idx == FW'(g));
    assign hit_ld = ld_en && (ld_idx == FW'(g));
    assign fld_en = hit_wr | hit_ld;
    assign fld_d  = hit_wr ? wr_val : ld_val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q <= '0;
      end else if (fld_en) begin
        fld_q <= fld_d;
      end
    end

    assign flat[4*g +: 4] = fld_q;
  end

  assign ra_val = flat[4*ra_idx +: 4];
  assign rb_val = flat[4*rb_idx +: 4];
  assign rd_val = flat[4*rd_idx +: 4];

endmodule

// File: rtl/cr_seq_ctrl.sv
module cr_seq_ctrl
  import cr_seq_pkg::*;
#(
  parameter int MAXVL = 8,
  localparam int VW = $clog2(MAXVL + 1),
  localparam int IW = $clog2(MAXVL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] vl_in,
  input  logic          rev,
  input  logic          incl,
  input  logic          fail,
  output logic          busy,
  output logic [IW-1:0] elem_idx,
  output logic [VW-1:0] vl_cur,
  output logic [VW-1:0] vl_out,
  output logic          done
);

  seq_st_t       st_q, st_d;
  logic [VW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] vl_q, vl_d;
  logic [VW-1:0] vlo_q, vlo_d;
  logic          rev_q, rev_d;
  logic          done_d;
  logic          run_en;
  logic [VW-1:0] vl_clamp;
  logic [VW-1:0] pos;

  assign vl_clamp = (vl_in > VW'(MAXVL)) ? VW'(MAXVL) : vl_in;
  assign pos      = rev_q ? (vl_q - VW'(1) - cnt_q) : cnt_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    vl_d   = vl_q;
    vlo_d  = vlo_q;
    rev_d  = rev_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          vl_d  = vl_clamp;
          rev_d = rev;
          cnt_d = '0;
          if (vl_clamp == '0) begin
            done_d = 1'b1;
            vlo_d  = '0;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (fail) begin
          vlo_d  = incl ? (cnt_q + VW'(1)) : cnt_q;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (cnt_q == vl_q - VW'(1)) begin
          vlo_d  = vl_q;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q + VW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign run_en = start | (st_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      vl_q   <= '0;
      vlo_q  <= '0;
      rev_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= done_d;
      if (run_en) begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
        vl_q  <= vl_d;
        vlo_q <= vlo_d;
        rev_q <= rev_d;
      end
    end
  end

  assign busy     = (st_q == ST_RUN);
  assign elem_idx = pos[IW-1:0];
  assign vl_cur   = vl_q;
  assign vl_out   = vlo_q;

endmodule

// File: rtl/cr_vec_seq.sv
module cr_vec_seq
  import cr_seq_pkg::*;
#(
  parameter int NF    = 16,
  parameter int MAXVL = 8,
  localparam int FW = $clog2(NF),
  localparam int VW = $clog2(MAXVL + 1),
  localparam int IW = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [FW-1:0]    ld_idx,
  input  logic [3:0]       ld_val,
  input  logic             start,
  input  logic [VW-1:0]    vl_in,
  input  logic [FW-1:0]    ba_base,
  input  logic [FW-1:0]    bb_base,
  input  logic [FW-1:0]    bt_base,
  input  logic [1:0]       ba_sel,
  input  logic [1:0]       bb_sel,
  input  logic [1:0]       bt_sel,
  input  logic [3:0]       op_tt,
  input  logic             fld_mode,
  input  logic             rev,
  input  logic             pred_en,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             sz,
  input  logic             dz,
  input  logic             snz,
  input  logic             par_red,
  input  logic             ff_en,
  input  logic             ff_inv,
  input  logic             ff_vli,
  input  logic [1:0]       ff_sel,
  output logic [4*NF-1:0]  rf_flat,
  output logic [VW-1:0]    vl_out,
  output logic             done
);

  seq_cfg_t         cfg_d, cfg_q;
  logic [FW-1:0]    ba_q, bb_q, bt_q;
  logic [MAXVL-1:0] src_q, dst_q;
  logic             busy_w;
  logic             cfg_en;
  logic [IW-1:0]    eidx;
  logic [VW-1:0]    vl_cur_w;
  logic [FW-1:0]    fa_idx, fb_idx, fd_idx;
  logic [3:0]       fa_val, fb_val, fd_val;
  logic             eu_we, eu_fail;
  logic [3:0]       eu_val;

  assign cfg_en = start & ~busy_w;

  always_comb begin
    cfg_d.op_tt    = op_tt;
    cfg_d.fld_mode = fld_mode;
    cfg_d.rev      = rev;
    cfg_d.ba_sel   = ba_sel;
    cfg_d.bb_sel   = bb_sel;
    cfg_d.bt_sel   = bt_sel;
    cfg_d.pred_en  = pred_en;
    cfg_d.sz       = sz;
    cfg_d.dz       = par_red ? sz : dz;
    cfg_d.snz      = snz;
    cfg_d.ff_en    = ff_en;
    cfg_d.ff_inv   = ff_inv;
    cfg_d.ff_vli   = ff_vli;
    cfg_d.ff_sel   = ff_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ba_q  <= '0;
      bb_q  <= '0;
      bt_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
      ba_q  <= ba_base;
      bb_q  <= bb_base;
      bt_q  <= bt_base;
      src_q <= src_mask;
      dst_q <= dst_mask;
    end
  end

  cr_seq_ctrl #(.MAXVL(MAXVL)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vl_in    (vl_in),
    .rev      (rev),
    .incl     (cfg_q.ff_vli),
    .fail     (busy_w & eu_fail),
    .busy     (busy_w),
    .elem_idx (eidx),
    .vl_cur   (vl_cur_w),
    .vl_out   (vl_out),
    .done     (done)
  );

  assign fa_idx = ba_q + FW'(eidx);
  assign fb_idx = bb_q + FW'(eidx);
  assign fd_idx = bt_q + FW'(eidx);

  cr_field_rf #(.NF(NF)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en & ~busy_w),
    .ld_idx (ld_idx),
    .ld_val (ld_val),
    .wr_en  (busy_w & eu_we),
    .wr_idx (fd_idx),
    .wr_val (eu_val),
    .ra_idx (fa_idx),
    .rb_idx (fb_idx),
    .rd_idx (fd_idx),
    .ra_val (fa_val),
    .rb_val (fb_val),
    .rd_val (fd_val),
    .flat   (rf_flat)
  );

  cr_elem_unit u_eu (
    .cfg    (cfg_q),
    .src_p  (src_q[eidx]),
    .dst_p  (dst_q[eidx]),
    .a_fld  (fa_val),
    .b_fld  (fb_val),
    .d_fld  (fd_val),
    .wr_en  (eu_we),
    .wr_val (eu_val),
    .fail   (eu_fail)
  );

endmodule

// File: rtl/cr_vec_seq_chk.sv
module cr_vec_seq_chk #(
  parameter int NF    = 16,
  parameter int MAXVL = 8,
  localparam int VW = $clog2(MAXVL + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            ld_en,
  input logic [VW-1:0]   vl_in,
  input logic            busy,
  input logic            done,
  input logic [VW-1:0]   vl_out,
  input logic [VW-1:0]   vl_cur,
  input logic [4*NF-1:0] rf_flat
);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= vl_cur));

  // R10
  vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vl_out) |-> done);

  // R11
  zero_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && vl_in == '0) |=> (done && vl_out == '0));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vl_cur));

  // R1
  idle_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_en) |=> $stable(rf_flat));

endmodule

bind cr_vec_seq cr_vec_seq_chk #(.NF(NF), .MAXVL(MAXVL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .ld_en   (ld_en),
  .vl_in   (vl_in),
  .busy    (busy_w),
  .done    (done),
  .vl_out  (vl_out),
  .vl_cur  (vl_cur_w),
  .rf_flat (rf_flat)
);

// File: tb/test_cr_vec_seq.sv
`timescale 1ns/1ps
module test_cr_vec_seq;

  localparam int NF    = 16;
  localparam int MAXVL = 8;
  localparam int FW    = 4;
  localparam int VW    = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ld_en;
  logic [FW-1:0]    ld_idx;
  logic [3:0]       ld_val;
  logic             start;
  logic [VW-1:0]    vl_in;
  logic [FW-1:0]    ba_base, bb_base, bt_base;
  logic [1:0]       ba_sel, bb_sel, bt_sel;
  logic [3:0]       op_tt;
  logic             fld_mode, rev, pred_en;
  logic [MAXVL-1:0] src_mask, dst_mask;
  logic             sz, dz, snz, par_red;
  logic             ff_en, ff_inv, ff_vli;
  logic [1:0]       ff_sel;
  logic [4*NF-1:0]  rf_flat;
  logic [VW-1:0]    vl_out;
  logic             done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] init_f [NF];
  logic [3:0] em [NF];

  always #5 clk = ~clk;

  cr_vec_seq #(.NF(NF), .MAXVL(MAXVL)) i_cr_vec_seq (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .start(start), .vl_in(vl_in), .ba_base(ba_base), .bb_base(bb_base),
    .bt_base(bt_base), .ba_sel(ba_sel), .bb_sel(bb_sel), .bt_sel(bt_sel),
    .op_tt(op_tt), .fld_mode(fld_mode), .rev(rev), .pred_en(pred_en),
    .src_mask(src_mask), .dst_mask(dst_mask), .sz(sz), .dz(dz), .snz(snz),
    .par_red(par_red), .ff_en(ff_en), .ff_inv(ff_inv), .ff_vli(ff_vli),
    .ff_sel(ff_sel), .rf_flat(rf_flat), .vl_out(vl_out), .done(done)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4*NF-1:0] pack_em();
    logic [4*NF-1:0] r;
    for (int f = 0; f < NF; f++) r[4*f +: 4] = em[f];
    return r;
  endfunction

  task automatic set_defaults();
    vl_in = 4'd8; ba_base = 0; bb_base = 0; bt_base = 0;
    ba_sel = 0; bb_sel = 0; bt_sel = 0; op_tt = 4'b1000;
    fld_mode = 0; rev = 0; pred_en = 0; src_mask = '1; dst_mask = '1;
    sz = 0; dz = 0; snz = 0; par_red = 0;
    ff_en = 0; ff_inv = 0; ff_vli = 0; ff_sel = 0;
  endtask

  task automatic load_all();
    for (int f = 0; f < NF; f++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = FW'(f); ld_val = init_f[f];
    end
    @(negedge clk);
    ld_en = 1'b0;
    for (int f = 0; f < NF; f++) em[f] = init_f[f];
  endtask

  // Bench model built from the requirements
  task automatic model(output int n, output int vx);
    int vle;
    logic dzv;
    vle = (int'(vl_in) > MAXVL) ? MAXVL : int'(vl_in);
    dzv = par_red ? sz : dz;
    n = vle; vx = vle;
    for (int p = 0; p < vle; p++) begin
      int i, ia, ib, id;
      logic [3:0] a, b, nd;
      logic soff, doff, wr, tb;
      i  = rev ? (vle - 1 - p) : p;
      ia = (int'(ba_base) + i) % NF;
      ib = (int'(bb_base) + i) % NF;
      id = (int'(bt_base) + i) % NF;
      a = em[ia]; b = em[ib]; nd = em[id];
      soff = pred_en && !src_mask[i];
      doff = pred_en && !dst_mask[i];
      if (soff && sz) begin a = {4{snz}}; b = {4{snz}}; end
      if (doff && dzv) begin
        wr = 1'b1;
        if (fld_mode) nd = {4{snz}}; else nd[bt_sel] = snz;
      end else if (doff || (soff && !sz)) begin
        wr = 1'b0;
      end else begin
        wr = 1'b1;
        if (fld_mode) begin
          for (int k = 0; k < 4; k++) nd[k] = op_tt[{a[k], b[k]}];
        end else begin
          nd[bt_sel] = op_tt[{a[ba_sel], b[bb_sel]}];
        end
      end
      if (wr) em[id] = nd;
      tb = fld_mode ? nd[ff_sel] : nd[bt_sel];
      if (wr && ff_en && (tb == ff_inv)) begin
        n = p + 1;
        vx = p + (ff_vli ? 1 : 0);
        return;
      end
    end
  endtask

  task automatic trial(string tag, bit mid_start, bit mid_ld);
    int n, vx, cyc;
    logic [4*NF-1:0] exp_flat;
    logic [VW-1:0] keep_vl;
    load_all();
    model(n, vx);
    exp_flat = pack_em();
    keep_vl = vl_in;
    @(negedge clk);
    start = 1'b1;
    cyc = 0;
    forever begin
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0; vl_in = keep_vl;
      cyc++;
      if (done || cyc > 40) break;
      if (cyc == 1 && mid_start) begin start = 1'b1; vl_in = 4'd2; end
      if (cyc == 1 && mid_ld) begin ld_en = 1'b1; ld_idx = 4'd15; ld_val = ~init_f[15]; end
    end
    check(done == 1'b1, {tag, " R11 done seen"}, 64'(done), 64'd1);
    check(cyc == n + 1, {tag, " R11 done cycle"}, 64'(cyc), 64'(n + 1));
    check(vl_out == VW'(vx), {tag, " R10 vl_out"}, 64'(vl_out), 64'(vx));
    check(rf_flat == exp_flat, {tag, " R2 R4 R5 R6 R7 R8 R9 fields"}, rf_flat, exp_flat);
    @(negedge clk);
    check(done == 1'b0, {tag, " R11 done width"}, 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; start = 0; ld_en = 0; ld_idx = 0; ld_val = 0;
    set_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rf_flat == '0, "R1 reset fields", rf_flat, 64'd0);
    check(vl_out == '0 && done == 1'b0, "R1 reset vl/done", {vl_out, 3'b0, done}, 64'd0);

    // R1: load pattern and read back
    for (int f = 0; f < NF; f++) init_f[f] = 4'(f * 7 + 3);
    load_all();
    @(negedge clk);
    check(rf_flat == pack_em(), "R1 load", rf_flat, pack_em());

    // R3: reverse cascade, AND with B one field above destination, bit 2
    set_defaults();
    for (int f = 0; f < NF; f++) init_f[f] = 4'b0100;
    init_f[10] = 4'b0000;
    ba_base = 4; bb_base = 5; bt_base = 4; ba_sel = 2; bb_sel = 2; bt_sel = 2;
    rev = 1;
    trial("R3 reverse cascade", 0, 0);
    check(rf_flat[4*4 +: 4] == 4'b0000, "R3 cascade reaches element 0", rf_flat[4*4 +: 4], 64'd0);
    rev = 0;
    trial("R2 forward no cascade", 0, 0);
    check(rf_flat[4*4 +: 4] == 4'b0100, "R2 forward keeps element 0", rf_flat[4*4 +: 4], 64'h4);

    // R10: first element fails, exclusive then inclusive
    set_defaults();
    for (int f = 0; f < NF; f++) init_f[f] = 4'b0000;
    ff_en = 1; ff_vli = 0;
    trial("R10 first fail excl", 0, 0);
    check(vl_out == 0, "R10 excl gives 0", 64'(vl_out), 64'd0);
    ff_vli = 1;
    trial("R10 first fail incl", 0, 0);
    check(vl_out == 1, "R10 incl gives 1", 64'(vl_out), 64'd1);
    ff_inv = 1; ff_vli = 0;
    trial("R9 inverted passes", 0, 0);
    check(vl_out == 8, "R9 inverted full VL", 64'(vl_out), 64'd8);

    // R11: zero length and clamp
    set_defaults();
    vl_in = 0;
    trial("R11 zero VL", 0, 0);
    vl_in = 4'd15;
    trial("R11 clamp VL", 0, 0);
    check(vl_out == 8, "R11 clamp to MAXVL", 64'(vl_out), 64'd8);

    // R7 / R8: destination forcing with ones
    set_defaults();
    for (int f = 0; f < NF; f++) init_f[f] = 4'($urandom);
    pred_en = 1; dst_mask = 8'b1010_0101; dz = 1; snz = 1; fld_mode = 1; bt_base = 8;
    trial("R7 forced ones", 0, 0);
    dz = 0; par_red = 1; sz = 1; src_mask = 8'b0011_1100;
    trial("R8 shared zeroing", 0, 0);

    // R12: start and load during a run are ignored
    set_defaults();
    for (int f = 0; f < NF; f++) init_f[f] = 4'($urandom);
    op_tt = 4'b0110; bt_base = 2;
    trial("R12 busy start/load", 1, 1);

    // Random mix
    for (int t = 0; t < 300; t++) begin
      for (int f = 0; f < NF; f++) init_f[f] = 4'($urandom);
      vl_in = VW'($urandom % 11);
      ba_base = FW'($urandom); bb_base = FW'($urandom); bt_base = FW'($urandom);
      ba_sel = 2'($urandom); bb_sel = 2'($urandom); bt_sel = 2'($urandom);
      op_tt = 4'($urandom); fld_mode = 1'($urandom); rev = 1'($urandom);
      pred_en = 1'($urandom); src_mask = MAXVL'($urandom); dst_mask = MAXVL'($urandom);
      sz = 1'($urandom); dz = 1'($urandom); snz = 1'($urandom); par_red = 1'($urandom);
      ff_en = 1'($urandom); ff_inv = 1'($urandom); ff_vli = 1'($urandom);
      ff_sel = 2'($urandom);
      trial("random", 0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule